// File: doc/BRIEF.md
# Centered-Clock Synchronous Serial Transmitter

The block shifts a 16-bit word out over two wires, a data line and a clock line. The most significant bit goes first. Within every bit the data line is set first. The clock stays low for a setup interval, is high for a pulse interval and then low for a hold interval, so the rising edge falls well inside a stable data bit. After the sixteenth bit both wires are held low for an idle gap. Only after that gap can another word start.

A host raises `load_i` for one cycle with the word on `word_i` while `busy_o` is low. The word is captured at that point. The host may change `word_i` during the transfer. All interval lengths are parameters counted in system-clock cycles, and each must be at least 1. The defaults give equal setup, pulse and hold times, so the clock is high for one third of each bit.

Top module: `midclk_ser_tx`

## Requirements
- R1: The captured word goes out most significant bit first. During bit b (b = 0 for the first bit), `data_o` carries `word[15-b]`.
- R2: Each bit lasts SETUP_CYC + HIGH_CYC + HOLD_CYC cycles. `sclk_o` is low for the first SETUP_CYC cycles, high for the next HIGH_CYC cycles and low for the last HOLD_CYC cycles. The first bit appears on `data_o` in the cycle after acceptance.
- R3: `data_o` changes only while `sclk_o` is low, both in the cycle of the change and in the cycle before it.
- R4: After the last bit's hold interval, `data_o` and `sclk_o` stay low for GAP_CYC cycles while `busy_o` stays high.
- R5: A `load_i` pulse is accepted only on a clock edge at which `busy_o` is low. A pulse while busy has no effect on the lines or on the busy time. Changes on `word_i` after acceptance have no effect on the transmitted bits.
- R6: `busy_o` rises in the cycle after acceptance and stays high for exactly 16*(SETUP_CYC+HIGH_CYC+HOLD_CYC)+GAP_CYC cycles.
- R7: Whenever `busy_o` is low, `data_o` and `sclk_o` are low.
- R8: A synchronous active-high `rst` forces `data_o`, `sclk_o` and `busy_o` low in the cycle after the edge at which it is sampled, even in the middle of a packet.
- R9: Every high pulse on `sclk_o` lasts exactly HIGH_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start strobe, accepted when not busy |
| word_i | input | 16 | Word to transmit, captured on acceptance |
| busy_o | output | 1 | High from acceptance until the idle gap ends |
| data_o | output | 1 | Serial data line, idles low |
| sclk_o | output | 1 | Serial clock line, idles low |

## Verification
The bench uses unequal setup, pulse and hold counts, so an interval that is swapped or miscounted changes the waveform. The word patterns are 0xAAAD, 0x0000, 0xFFFF, 0x8001 and 0x5A3C. Alternating bits show a wrong bit order. The all-zero and all-one words show a stuck data line or an off-by-one bit count. 0x8001 exposes an end bit that is lost or duplicated. Each pattern is transmitted while `word_i` is flipped and a stray load is pulsed, so the bench also sees whether the captured word is held. A load held high across the end of the gap, and a reset mid-packet, check the acceptance boundary and the forced idle state.

// File: rtl/midclk_pkg.sv
package midclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_HOLD,
        ST_GAP
    } tx_state_e;

endpackage

// File: rtl/midclk_interval_timer.sv
// Down-counter that reports when the loaded interval has run out.
module midclk_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/midclk_word_shifter.sv
// Holds the captured word; its top bit is the bit currently on the line.
module midclk_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o
);
    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = word_i;
        end else if (shift_i) begin
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign msb_o = sh_q[WORD_W-1];
endmodule

// File: rtl/midclk_ser_tx.sv
module midclk_ser_tx #(
    parameter int WORD_W    = 16,
    parameter int SETUP_CYC = 4,
    parameter int HIGH_CYC  = 4,
    parameter int HOLD_CYC  = 4,
    parameter int GAP_CYC   = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              busy_o,
    output logic              data_o,
    output logic              sclk_o
);
    import midclk_pkg::*;

    localparam int MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int MAX_B = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam int IDX_W = $clog2(WORD_W);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [IDX_W-1:0] bits_left;
        logic             drive;
        logic             sclk;
        logic             busy;
    } tx_regs_t;

    tx_regs_t         r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             sh_load;
    logic             sh_shift;
    logic             sh_msb;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    r_d.state     = ST_SETUP;
                    r_d.bits_left = LAST_IDX;
                    r_d.drive     = 1'b1;
                    r_d.busy      = 1'b1;
                    sh_load       = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    r_d.state = ST_HIGH;
                    r_d.sclk  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = HIGH_LD;
                end
            end
            ST_HIGH: begin
                if (tmr_done) begin
                    r_d.state = ST_HOLD;
                    r_d.sclk  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = HOLD_LD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (r_q.bits_left == '0) begin
                        r_d.state = ST_GAP;
                        r_d.drive = 1'b0;
                        tmr_val   = GAP_LD;
                    end else begin
                        r_d.state     = ST_SETUP;
                        r_d.bits_left = r_q.bits_left - 1'b1;
                        sh_shift      = 1'b1;
                        tmr_val       = SETUP_LD;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.busy  = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state     <= ST_IDLE;
            r_q.bits_left <= '0;
            r_q.drive     <= 1'b0;
            r_q.sclk      <= 1'b0;
            r_q.busy      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    midclk_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_done)
    );

    midclk_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sh_load),
        .word_i  (word_i),
        .shift_i (sh_shift),
        .msb_o   (sh_msb)
    );

    assign busy_o = r_q.busy;
    assign sclk_o = r_q.sclk;
    assign data_o = sh_msb & r_q.drive;
endmodule

// File: rtl/midclk_ser_tx_chk.sv
module midclk_ser_tx_chk #(
    parameter int HIGH_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic load_i,
    input logic busy_o,
    input logic data_o,
    input logic sclk_o
);
    int hi_run;

    always_ff @(posedge clk) begin
        if (rst)         hi_run <= 0;
        else if (sclk_o) hi_run <= hi_run + 1;
        else             hi_run <= 0;
    end

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!data_o && !sclk_o));

    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(data_o) |-> (!sclk_o && !$past(sclk_o)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !data_o && !sclk_o));

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_i) && !$past(busy_o)) |-> busy_o);

    // R9
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(sclk_o)) |-> (hi_run == HIGH_CYC));
endmodule

bind midclk_ser_tx midclk_ser_tx_chk #(.HIGH_CYC(HIGH_CYC)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .busy_o (busy_o),
    .data_o (data_o),
    .sclk_o (sclk_o)
);

// File: tb/sim_midclk_ser_tx.sv
module sim_midclk_ser_tx;
    localparam int S = 2;
    localparam int H = 3;
    localparam int D = 4;
    localparam int G = 10;
    localparam int P = S + H + D;
    localparam int BUSY_LEN = 16 * P + G;
    localparam int NV = 5;
    localparam logic [15:0] VEC [NV] = '{16'hAAAD, 16'h0000, 16'hFFFF, 16'h8001, 16'h5A3C};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] word = '0;
    logic        busy, dout, sclk;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    midclk_ser_tx #(.WORD_W(16), .SETUP_CYC(S), .HIGH_CYC(H), .HOLD_CYC(D), .GAP_CYC(G)) u0 (
        .clk(clk), .rst(rst), .load_i(load), .word_i(word),
        .busy_o(busy), .data_o(dout), .sclk_o(sclk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Sends w, flips word_i and pulses a stray load mid-packet, then checks every cycle.
    task automatic run_word(input logic [15:0] w);
        int wave_err = 0;
        int gap_err = 0;
        int busy_len = 0;
        logic [15:0] rx = '0;
        logic prev_s = 1'b0;
        @(negedge clk);
        word = w;
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load = 1'b0;
        word = ~w;
        for (int t = 0; t < BUSY_LEN + 2; t++) begin
            logic ed, es, eb;
            eb = (t < BUSY_LEN);
            if (t < 16 * P) begin
                ed = w[15 - t / P];
                es = ((t % P) >= S) && ((t % P) < S + H);
            end else begin
                ed = 1'b0;
                es = 1'b0;
            end
            if (dout !== ed || sclk !== es) begin
                if (t >= 16 * P) gap_err++;
                else wave_err++;
            end
            if (sclk && !prev_s) rx = {rx[14:0], dout};
            prev_s = sclk;
            if (busy) busy_len++;
            load = (t == 5 || t == 40);
            @(negedge clk);
        end
        load = 1'b0;
        chk(wave_err == 0, "R2 bit timing / R5 ignore", wave_err, 0);
        chk(rx == w, "R1 msb-first word", rx, w);
        chk(gap_err == 0, "R4 idle gap low", gap_err, 0);
        chk(busy_len == BUSY_LEN, "R6 busy length", busy_len, BUSY_LEN);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!busy && !dout && !sclk, "R8 reset state", {busy, dout, sclk}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R7 idle lines
        chk(!busy && !dout && !sclk, "R7 idle low", {busy, dout, sclk}, 0);

        for (int i = 0; i < NV; i++) run_word(VEC[i]);

        // R5 boundary: load held high across the end of the gap
        @(negedge clk);
        word = 16'hC3A5;
        load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        word = 16'h0000;
        repeat (BUSY_LEN - 1) @(negedge clk);
        chk(busy == 1'b1, "R5 busy at last gap cycle", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R6 busy clears after gap", busy, 0);
        word = 16'h8000;
        @(negedge clk);
        chk(busy && dout && !sclk, "R5 reaccept when idle", {busy, dout, sclk}, 3'b110);
        load = 1'b0;

        // R8 reset mid-packet, while clock is high
        repeat (S) @(negedge clk);
        chk(sclk == 1'b1, "R2 clock high before reset", sclk, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !dout && !sclk, "R8 mid-packet reset", {busy, dout, sclk}, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !dout && !sclk, "R7 stays idle after reset", {busy, dout, sclk}, 0);

        // back-to-back after reset, default test word
        run_word(16'hAAAD);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule